// File: doc/BRIEF.md
# Self-Starting Rotating Segment Indicator

This block is a free-running six-bit register that needs no data input. Each clock edge moves the register contents one place toward the high end. When the register holds no ones, the next edge places a one in bit 0. A single lit bit therefore travels from bit 0 to bit 5, leaves the register, and the sequence starts again on its own. The block needs no seed load and no feedback ring.

The six bits drive the six outer segments of a common-anode seven-segment digit, so the segment outputs are active low. The lit segment circles the digit clockwise and the center segment stays dark. The intended clock is slow, around 1 Hz, so that the eye can follow the motion. One revolution takes seven clocks: six states with one segment lit, then one blank state.

Top module: `seg_rotator`

## Requirements
- R1: While `rst` is high at a clock edge, `ring_state` becomes 000000 after that edge, and every line of `seg_n` reads 1 (unlit).
- R2: At each clock edge without reset, bits 5..1 of `ring_state` take the values that bits 4..0 held before the edge.
- R3: At an edge without reset, bit 0 becomes 1 when `ring_state` was 000000 before the edge. Otherwise bit 0 becomes 0.
- R4: After reset is released, `ring_state` repeats the seven-clock sequence 000001, 000010, 000100, 001000, 010000, 100000, 000000. The first clock after release gives 000001.
- R5: For each i from 0 to 5, `seg_n[i]` is the inverse of `ring_state[i]`. Bit 0 drives the top segment, bit 1 upper right, bit 2 lower right, bit 3 bottom, bit 4 lower left and bit 5 upper left.
- R6: `seg_n[6]` drives the center segment and is always 1 (unlit).
- R7: Starting from reset, `ring_state` never holds more than one set bit.
- R8: A reset asserted part way through the sequence clears the state. The first clock after reset is released then gives 000001 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow rotation clock |
| rst | input | 1 | Synchronous reset, active high |
| ring_state | output | 6 | Current register contents, one bit per outer segment |
| seg_n | output | 7 | Active-low segment lines; bits 0..5 are the outer segments clockwise from the top, bit 6 is the center |

## Verification
The assertions check the following on every cycle: the shift relation between neighbouring bits, the refill from the empty state, the absence of a refill from any other state, the one-hot-or-empty invariant, the link between segments and bits, and the dark center segment. The order and length of a full revolution can only be shown by the bench. It compares many consecutive revolutions against a phase counter modulo seven. The bench scenarios also cover a reset in the middle of a revolution and the restart that follows it.

// File: rtl/seg_rotator_pkg.sv
package seg_rotator_pkg;

  localparam int unsigned RING_BITS = 6;
  localparam int unsigned SEG_LINES = RING_BITS + 1;

  typedef logic [RING_BITS-1:0] ring_t;
  typedef logic [SEG_LINES-1:0] seg_t;

  // Next register value: shift toward the high end, and insert a one only when the register is empty.
  function automatic ring_t ring_advance(input ring_t cur);
    ring_t nxt;
    nxt = {cur[RING_BITS-2:0], 1'b0};
    nxt[0] = (cur == '0);
    return nxt;
  endfunction

  // Active-low drive: outer segments follow the bits, the center stays dark.
  function automatic seg_t seg_drive(input ring_t cur);
    seg_t s;
    s = {1'b1, ~cur};
    return s;
  endfunction

endpackage

// File: rtl/ring_stepper.sv
module ring_stepper
  import seg_rotator_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  output ring_t state,
  output logic  refill_evt
);

  ring_t state_q;
  ring_t state_d;

  always_comb begin
    state_d = ring_advance(state_q);
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= '0;
    else     state_q <= state_d;
  end

  assign state      = state_q;
  assign refill_evt = (state_q == '0);

endmodule

// File: rtl/seg_encoder.sv
module seg_encoder
  import seg_rotator_pkg::*;
(
  input  ring_t bits_in,
  output seg_t  seg_n
);

  seg_t drive;

  always_comb begin
    drive = seg_drive(bits_in);
  end

  genvar gi;
  generate
    for (gi = 0; gi < SEG_LINES; gi++) begin : g_line
      assign seg_n[gi] = drive[gi];
    end
  endgenerate

endmodule

// File: rtl/seg_rotator.sv
module seg_rotator
  import seg_rotator_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  output logic [5:0] ring_state,
  output logic [6:0] seg_n
);

  ring_t cur_state;
  seg_t  seg_lines;
  logic  refill_evt;

  ring_stepper u_step (
    .clk        (clk),
    .rst        (rst),
    .state      (cur_state),
    .refill_evt (refill_evt)
  );

  seg_encoder u_enc (
    .bits_in (cur_state),
    .seg_n   (seg_lines)
  );

  assign ring_state = cur_state;
  assign seg_n      = seg_lines;

endmodule

// File: rtl/seg_rotator_chk.sv
module seg_rotator_chk (
  input logic       clk,
  input logic       rst,
  input logic [5:0] ring_state,
  input logic [6:0] seg_n,
  input logic       refill_evt
);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (ring_state == 6'b0)); // R1
  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (ring_state[5:1] == $past(ring_state[4:0]))); // R2
  AST_REFILL: assert property (@(posedge clk) disable iff (rst)
    refill_evt |=> (ring_state == 6'b000001)); // R3
  AST_NO_REFILL: assert property (@(posedge clk) disable iff (rst)
    (ring_state != 6'b0) |=> !ring_state[0]); // R3
  AST_SEG_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    seg_n[5:0] == ~ring_state); // R5
  AST_CENTER_DARK: assert property (@(posedge clk) disable iff (rst)
    seg_n[6]); // R6
  AST_ONE_LIT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ring_state)); // R7

endmodule

bind seg_rotator seg_rotator_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .ring_state (ring_state),
  .seg_n      (seg_n),
  .refill_evt (refill_evt)
);

// File: tb/seg_rotator_test.sv
`timescale 1ns/1ps
module seg_rotator_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] ring_state;
  logic [6:0] seg_n;

  int checks = 0;
  int fails  = 0;
  int phase  = 0;
  logic [5:0] prev_state;

  always #10 clk = ~clk;

  seg_rotator uut (
    .clk        (clk),
    .rst        (rst),
    .ring_state (ring_state),
    .seg_n      (seg_n)
  );

  function automatic logic [5:0] expect_at(input int ph);
    int k;
    k = ph % 7;
    if (k == 0) return 6'b0;
    return 6'(1 << (k - 1));
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step_and_check();
    prev_state = ring_state;
    @(posedge clk);
    @(negedge clk);
    phase++;
    check("R4", {1'b0, ring_state}, {1'b0, expect_at(phase)});
    check("R2", {2'b0, ring_state[5:1]}, {2'b0, prev_state[4:0]});
    check("R3", {6'b0, ring_state[0]}, {6'b0, (prev_state == 6'b0)});
    check("R5", {1'b0, seg_n[5:0]}, {1'b0, ~ring_state});
    check("R6", {6'b0, seg_n[6]}, 7'b1);
    check("R7", {6'b0, ($countones(ring_state) <= 1)}, 7'b1);
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {1'b0, ring_state}, 7'b0);
    check("R1", seg_n, 7'b1111111);
    rst = 1'b0;
    phase = 0;
    for (int i = 0; i < 70; i++) step_and_check();
    // Reset in the middle of a revolution.
    for (int j = 1; j < 7; j++) begin
      for (int i = 0; i < j; i++) step_and_check();
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R8", {1'b0, ring_state}, 7'b0);
      check("R1", seg_n, 7'b1111111);
      rst = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check("R8", {1'b0, ring_state}, 7'b0000001);
      check("R5", seg_n, 7'b1111110);
      phase = 1;
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule